// File: doc/BRIEF.md
# Fetch-Side Branch Direction and Target Predictor

This unit tells the fetch stage where to go next for each fetched instruction. The caller supplies the fetch address, the branch kind found at decode, the signed displacement and an optional software direction hint. The unit returns a taken flag, the next fetch address, and a flag that marks whether that address can be trusted.

Conditional branches are looked up in a direct-mapped target buffer. Each entry holds a tag, a target and a two-bit saturating confidence counter. The retirement stage trains the buffer with resolved outcomes. When the buffer misses, a hint decides the direction if one is present. Without a hint, the displacement sign decides: backward branches are predicted taken and forward branches not taken. Calls push their return address onto a circular 16-deep return stack. Returns pop their target from that stack.

Top module: `branch_predict_unit`

## Requirements
- R1: After reset every buffer entry is invalid and the return stack is empty.
- R2: A fetch of kind none (`br_kind_i`=0) predicts not taken, with target pc+4 and target valid.
- R3: A conditional branch (kind 1) that misses the buffer and carries no hint is predicted taken with target pc+disp when disp is negative (bit 31 set). Otherwise it is predicted not taken with target pc+4.
- R4: A conditional branch that misses the buffer but has `hint_vld_i` set takes its direction from `hint_taken_i`, whatever the displacement sign. The target is pc+disp when taken and pc+4 when not.
- R5: A conditional branch hits when the entry at index pc[7:2] is valid and its tag equals pc[31:8]. On a hit the branch is predicted taken with the stored target when the counter is 2 or 3, and not taken with target pc+4 when the counter is 0 or 1. The hint and the displacement are ignored.
- R6: A retirement update that misses allocates the entry only when the branch was taken. The new entry gets counter 2 and the resolved target. An update that misses and was not taken leaves the buffer unchanged.
- R7: A retirement update that hits raises the counter on taken and lowers it on not taken, saturating at 3 and 0. It replaces the stored target only when taken.
- R8: Two addresses that share an index but differ in tag alias. A lookup with the other tag misses, and an allocation replaces the older entry.
- R9: A call (kind 2) is predicted taken with target pc+disp. When `fetch_vld_i` is high, the call pushes pc+4.
- R10: A return (kind 3) is predicted taken with the top of the stack as target, and when `fetch_vld_i` is high it pops. On an empty stack the target is pc+4 with `pred_tgt_vld_o` low, and the stack stays empty.
- R11: Pushing onto a full stack overwrites the oldest entry. After 17 pushes, 16 returns yield the newest 16 addresses in reverse order, and the 17th return sees an empty stack.
- R12: A buffer update becomes visible to lookups from the next cycle. A lookup in the same cycle sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_vld_i | input | 1 | Fetch slot valid; gates return-stack push and pop |
| fetch_pc_i | input | 32 | Address of the fetched instruction |
| br_kind_i | input | 2 | 0 none, 1 conditional, 2 call, 3 return |
| disp_i | input | 32 | Signed branch displacement |
| hint_vld_i | input | 1 | Software direction hint present |
| hint_taken_i | input | 1 | Hinted direction |
| upd_vld_i | input | 1 | Retirement update valid |
| upd_pc_i | input | 32 | Address of the retired branch |
| upd_taken_i | input | 1 | Resolved direction |
| upd_tgt_i | input | 32 | Resolved target |
| pred_taken_o | output | 1 | Predicted taken |
| pred_tgt_o | output | 32 | Predicted next fetch address |
| pred_tgt_vld_o | output | 1 | Low when a return found the stack empty |

## Verification
A corrupted buffer counter, tag or target appears at `pred_taken_o` or `pred_tgt_o` on the first conditional fetch to that index after the bad update. That fetch comes one cycle later in the directed cases. A stack pointer or depth count that drifts shows up on the next return, as a wrong target or a wrong `pred_tgt_vld_o`. Overwrite-on-full errors only appear after a full round of 16 pops, so a dedicated 17-push and 17-pop sequence exposes them. Random mixed traffic over four aliasing tags is compared with a bench model on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned INSN_B = 4;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_COND = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic            lk_taken_o,
  output logic [PC_W-1:0] lk_tgt_o,
  input  logic            upd_vld_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_tgt_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = PC_W - IDX_W - 2;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  logic [IDX_W-1:0] l_idx, u_idx;
  logic [TAG_W-1:0] l_tag, u_tag;
  logic             u_hit;

  assign l_idx = lk_pc_i[IDX_W+1:2];
  assign l_tag = lk_pc_i[PC_W-1:IDX_W+2];
  assign u_idx = upd_pc_i[IDX_W+1:2];
  assign u_tag = upd_pc_i[PC_W-1:IDX_W+2];

  assign lk_hit_o   = vld_q[l_idx] && (tag_q[l_idx] == l_tag);
  assign lk_taken_o = ctr_q[l_idx][1];
  assign lk_tgt_o   = tgt_q[l_idx];
  assign u_hit      = vld_q[u_idx] && (tag_q[u_idx] == u_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         vld_q <= '0;
    else if (upd_vld_i && upd_taken_i)   vld_q[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (upd_vld_i) begin
      if (u_hit) begin
        if (upd_taken_i) begin
          tgt_q[u_idx] <= upd_tgt_i;
          if (ctr_q[u_idx] != 2'd3) ctr_q[u_idx] <= ctr_q[u_idx] + 2'd1;
        end else if (ctr_q[u_idx] != 2'd0) begin
          ctr_q[u_idx] <= ctr_q[u_idx] - 2'd1;
        end
      end else if (upd_taken_i) begin
        tag_q[u_idx] <= u_tag;
        tgt_q[u_idx] <= upd_tgt_i;
        ctr_q[u_idx] <= 2'd2; // weakly taken on allocate
      end
    end
  end

  a_r6_alloc_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_vld_i && upd_taken_i) |=> vld_q[$past(u_idx)]);
  a_r7_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_vld_i && u_hit && upd_taken_i && ctr_q[u_idx] == 2'd3) |=> ctr_q[$past(u_idx)] == 2'd3);
  a_r7_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_vld_i && u_hit && !upd_taken_i && ctr_q[u_idx] == 2'd0) |=> ctr_q[$past(u_idx)] == 2'd0);
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PC_W-1:0] push_addr_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] top_o,
  output logic            empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [CNT_W-1:0] cnt_q;

  assign ptr_inc = (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? PTR_W'(DEPTH-1) : ptr_q - 1'b1;
  assign top_o   = mem_q[ptr_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= PTR_W'(DEPTH-1);
      cnt_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_inc;               // full: wraps over oldest
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      ptr_q <= ptr_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[ptr_inc] <= push_addr_i;
  end

  a_r11_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r11_full_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH));
  a_r10_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> (empty_o && $stable(ptr_q)));
endmodule

// File: rtl/branch_predict_unit.sv
module branch_predict_unit
  import bp_pkg::*;
#(
  parameter int unsigned BTB_ENTRIES = 64,
  parameter int unsigned RAS_DEPTH   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_vld_i,
  input  logic [31:0]     fetch_pc_i,
  input  logic [1:0]      br_kind_i,
  input  logic [31:0]     disp_i,
  input  logic            hint_vld_i,
  input  logic            hint_taken_i,
  input  logic            upd_vld_i,
  input  logic [31:0]     upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [31:0]     upd_tgt_i,
  output logic            pred_taken_o,
  output logic [31:0]     pred_tgt_o,
  output logic            pred_tgt_vld_o
);
  br_kind_e        kind;
  logic            btb_hit, btb_taken, ras_empty, stat_taken;
  logic [PC_W-1:0] btb_tgt, ras_top, fall_pc, jump_pc;

  assign kind    = br_kind_e'(br_kind_i);
  assign fall_pc = fetch_pc_i + PC_W'(INSN_B);
  assign jump_pc = fetch_pc_i + disp_i;

  bp_btb #(.PC_W(PC_W), .ENTRIES(BTB_ENTRIES)) u_btb (
    .clk_i, .rst_ni,
    .lk_pc_i(fetch_pc_i), .lk_hit_o(btb_hit), .lk_taken_o(btb_taken), .lk_tgt_o(btb_tgt),
    .upd_vld_i, .upd_pc_i, .upd_taken_i, .upd_tgt_i
  );

  bp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i, .rst_ni,
    .push_i(fetch_vld_i && kind == BK_CALL), .push_addr_i(fall_pc),
    .pop_i(fetch_vld_i && kind == BK_RET),
    .top_o(ras_top), .empty_o(ras_empty)
  );

  // static fallback: hint first, then backward-taken
  assign stat_taken = hint_vld_i ? hint_taken_i : disp_i[PC_W-1];

  always_comb begin
    pred_taken_o   = 1'b0;
    pred_tgt_o     = fall_pc;
    pred_tgt_vld_o = 1'b1;
    unique case (kind)
      BK_RET: begin
        pred_taken_o = 1'b1;
        if (ras_empty) pred_tgt_vld_o = 1'b0;
        else           pred_tgt_o     = ras_top;
      end
      BK_CALL: begin
        pred_taken_o = 1'b1;
        pred_tgt_o   = jump_pc;
      end
      BK_COND: begin
        if (btb_hit) begin
          pred_taken_o = btb_taken;
          if (btb_taken) pred_tgt_o = btb_tgt;
        end else begin
          pred_taken_o = stat_taken;
          if (stat_taken) pred_tgt_o = jump_pc;
        end
      end
      default: ;
    endcase
  end

  a_r2_none_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == BK_NONE) |-> (!pred_taken_o && pred_tgt_vld_o));
  a_r10_empty_ret_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == BK_RET && ras_empty) |-> (!pred_tgt_vld_o && pred_taken_o));
  a_r5_hit_overrides_hint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == BK_COND && btb_hit) |-> (pred_taken_o == btb_taken));
  a_r9_call_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == BK_CALL) |-> (pred_taken_o && pred_tgt_vld_o));
endmodule

// File: tb/branch_predict_unit_test.sv
module branch_predict_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [1:0]  kind = '0;
  logic [31:0] disp = '0;
  logic        hint_vld = 1'b0, hint_taken = 1'b0;
  logic        upd_vld = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_pc = '0, upd_tgt = '0;
  logic        p_taken, p_tgt_vld;
  logic [31:0] p_tgt;

  int unsigned n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  // bench model
  bit          m_vld [64];
  logic [23:0] m_tag [64];
  logic [31:0] m_tgt [64];
  int          m_ctr [64];
  logic [31:0] m_rs  [16];
  int          m_ptr, m_cnt;

  always #5 clk = ~clk;

  branch_predict_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_vld_i(fetch_vld), .fetch_pc_i(fetch_pc),
    .br_kind_i(kind), .disp_i(disp), .hint_vld_i(hint_vld), .hint_taken_i(hint_taken),
    .upd_vld_i(upd_vld), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken), .upd_tgt_i(upd_tgt),
    .pred_taken_o(p_taken), .pred_tgt_o(p_tgt), .pred_tgt_vld_o(p_tgt_vld)
  );

  function automatic logic [33:0] exp_pred();
    logic [31:0] fall = fetch_pc + 32'd4;
    logic [31:0] jmp  = fetch_pc + disp;
    int          ix   = int'(fetch_pc[7:2]);
    logic        tk;
    case (kind)
      2'd0: return {1'b0, 1'b1, fall};
      2'd2: return {1'b1, 1'b1, jmp};
      2'd3: return (m_cnt == 0) ? {1'b1, 1'b0, fall} : {1'b1, 1'b1, m_rs[m_ptr]};
      default: begin
        if (m_vld[ix] && m_tag[ix] == fetch_pc[31:8]) begin
          tk = (m_ctr[ix] >= 2);
          return {tk, 1'b1, tk ? m_tgt[ix] : fall};
        end
        tk = hint_vld ? hint_taken : disp[31];
        return {tk, 1'b1, tk ? jmp : fall};
      end
    endcase
  endfunction

  task automatic model_clock();
    int ix = int'(upd_pc[7:2]);
    if (upd_vld) begin
      if (m_vld[ix] && m_tag[ix] == upd_pc[31:8]) begin
        if (upd_taken) begin m_tgt[ix] = upd_tgt; if (m_ctr[ix] < 3) m_ctr[ix]++; end
        else if (m_ctr[ix] > 0) m_ctr[ix]--;
      end else if (upd_taken) begin
        m_vld[ix] = 1'b1; m_tag[ix] = upd_pc[31:8]; m_tgt[ix] = upd_tgt; m_ctr[ix] = 2;
      end
    end
    if (fetch_vld && kind == 2'd2) begin
      m_ptr = (m_ptr + 1) % 16; m_rs[m_ptr] = fetch_pc + 32'd4;
      if (m_cnt < 16) m_cnt++;
    end else if (fetch_vld && kind == 2'd3 && m_cnt > 0) begin
      m_ptr = (m_ptr + 15) % 16; m_cnt--;
    end
  endtask

  // inputs set at negedge, compared 1 ns later, model advanced at posedge
  task automatic step(input string req, input logic [1:0] k, input logic [31:0] pc,
                      input logic [31:0] d, input logic hv, input logic ht,
                      input logic uv, input logic [31:0] upc, input logic ut,
                      input logic [31:0] utg);
    logic [33:0] exp, got;
    fetch_vld = 1'b1; kind = k; fetch_pc = pc; disp = d; hint_vld = hv; hint_taken = ht;
    upd_vld = uv; upd_pc = upc; upd_taken = ut; upd_tgt = utg;
    #1;
    exp = exp_pred();
    got = {p_taken, p_tgt_vld, p_tgt};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got taken=%0b vld=%0b tgt=%h exp taken=%0b vld=%0b tgt=%h",
               req, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic upd_only(input logic [31:0] upc, input logic ut, input logic [31:0] utg);
    step("R12", 2'd0, 32'h9000, 0, 0, 0, 1'b1, upc, ut, utg);
  endtask

  localparam logic [31:0] PA = 32'h0000_1234 & ~32'h3;
  localparam logic [31:0] PB = 32'h0000_2040;
  localparam logic [31:0] PC2 = PA + 32'h0000_0100; // same index, other tag

  initial begin
    int dummy;
    dummy = $urandom(32'd1234);
    foreach (m_vld[i]) begin m_vld[i] = 1'b0; m_ctr[i] = 0; end
    m_ptr = 15; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    step("R1", 2'd3, 32'h100, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 2'd1, PA, 32'h40, 0, 0, 0, 0, 0, 0);
    // R2 non-branch
    step("R2", 2'd0, 32'h500, -32'sd64, 1, 1, 0, 0, 0, 0);
    // R3 static sign rule
    step("R3", 2'd1, 32'h800, -32'sd16, 0, 0, 0, 0, 0, 0);
    step("R3", 2'd1, 32'h800, 32'd16, 0, 0, 0, 0, 0, 0);
    // R4 hint overrides sign
    step("R4", 2'd1, 32'h800, 32'd16, 1, 1, 0, 0, 0, 0);
    step("R4", 2'd1, 32'h800, -32'sd16, 1, 0, 0, 0, 0, 0);
    // R12 lookup in the update cycle sees old contents
    step("R12", 2'd1, PA, 32'h40, 1, 0, 1, PA, 1, 32'hABC0);
    // R6 allocate on taken miss; R5 hit beats hint and sign
    step("R6", 2'd1, PA, 32'h40, 1, 0, 0, 0, 0, 0);
    step("R5", 2'd1, PA, -32'sd8, 0, 0, 0, 0, 0, 0);
    // R6 not-taken miss does not allocate
    upd_only(PB, 1'b0, 32'h7770);
    step("R6", 2'd1, PB, 32'h20, 0, 0, 0, 0, 0, 0);
    // R7 counter walk with saturation
    upd_only(PA, 1'b0, 0);
    step("R7", 2'd1, PA, -32'sd8, 0, 0, 0, 0, 0, 0);
    upd_only(PA, 1'b0, 0);
    upd_only(PA, 1'b0, 0);
    step("R7", 2'd1, PA, -32'sd8, 1, 1, 0, 0, 0, 0);
    upd_only(PA, 1'b1, 32'hBEE0);
    step("R7", 2'd1, PA, 32'h8, 0, 0, 0, 0, 0, 0);
    upd_only(PA, 1'b1, 32'hCAF0);
    step("R7", 2'd1, PA, 32'h8, 0, 0, 0, 0, 0, 0);
    upd_only(PA, 1'b1, 32'hD000);
    upd_only(PA, 1'b1, 32'hD100);
    upd_only(PA, 1'b0, 0);
    step("R7", 2'd1, PA, 32'h8, 0, 0, 0, 0, 0, 0);
    // R8 aliasing
    step("R8", 2'd1, PC2, 32'h8, 0, 0, 0, 0, 0, 0);
    upd_only(PC2, 1'b1, 32'h4440);
    step("R8", 2'd1, PC2, 32'h8, 0, 0, 0, 0, 0, 0);
    step("R8", 2'd1, PA, 32'h8, 0, 0, 0, 0, 0, 0);
    // R9 / R11 overflow the stack, then drain it
    for (int i = 0; i < 17; i++) step("R9", 2'd2, 32'h1_0000 + 32'(i * 16), 32'h400, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) step("R11", 2'd3, 32'h2_0000, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 2'd3, 32'h2_0000, 0, 0, 0, 0, 0, 0, 0);
    // random mix over four aliasing tags
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pc, upc;
      logic [1:0]  k;
      int          d;
      pc  = {22'd0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)), 2'b00};
      upc = {22'd0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)), 2'b00};
      k   = ($urandom_range(0, 9) < 6) ? 2'd1 : 2'($urandom_range(0, 3));
      d   = ($urandom_range(0, 511) - 256) * 4;
      step(k == 2'd1 ? "R5" : (k == 2'd3 ? "R10" : "R9"), k, pc, 32'(d),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), upc, 1'($urandom_range(0, 1)),
           {16'd0, 16'($urandom)} & ~32'h3);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule